// File: doc/BRIEF.md
# Three-Channel Reload Timer with Wide Free-Running Counter

This block is a memory-mapped timer bank. It has three down-counting channels that reload themselves, and one 40-bit up-counter that runs freely. Software reaches all of them through a single-cycle register port. Two external clock-enable strobes supply the count rates: a slow tick and a fast tick. Each down-counter chooses one of them through a bit in its control word. The free-running counter always advances on the fast tick.

Each down-counter has its own interrupt line. The line latches high when the counter underflows and stays high until software writes any value to that channel's clear register. Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. In periodic mode, a reload value N gives an underflow every N+1 selected ticks. With periodic mode off, the counter wraps to all ones instead.

The 40-bit counter is read in two steps. A read of its low word also takes a snapshot of the upper byte. A read of the high register then returns that snapshot, so the two halves stay consistent.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every counter, reload value, control word, interrupt line and the read data output are zero.
- R2: The channel bases are 0x00, 0x20 and 0x80. Within a channel, word offset +0x0 is the reload value, +0x4 the current count, +0x8 the control word and +0xC the interrupt clear register, which reads as zero. Read data appears on `rdata` in the cycle after `rd_en` is high and holds otherwise. Unmapped addresses read as zero.
- R3: In the control word, bit 7 enables counting, bit 6 selects periodic mode and bit 3 selects the fast tick. All other bits read as zero. While bit 7 is clear, the count holds.
- R4: A write to the reload register also copies the value into the counter. If a selected tick arrives in the same cycle, the write wins.
- R5: With counting enabled, the count falls by one on each selected tick. In periodic mode, a tick at count 0 reloads the reload value, so the underflow period is N+1 ticks.
- R6: With periodic mode off, a tick at count 0 wraps the counter to the all-ones value of its width.
- R7: The underflow tick sets the channel's interrupt line, which stays high until a write of any value to the clear register. An underflow in the same cycle as a clear keeps the line high.
- R8: Channels 0 and 1 hold 16 bits. Write bits 31:16 are dropped and read as zero. Channel 2 holds the full 32 bits.
- R9: The 40-bit counter starts when bit 8 of a write to 0x64 is set and stops when it is clear. While running, it increments once per fast tick. It drives no interrupt.
- R10: A read of 0x60 returns counter bits 31:0 and captures bits 39:32. A read of 0x64 returns the captured byte in bits 7:0 and the run enable in bit 8.
- R11: A channel with bit 3 clear ignores the fast tick and counts only on the slow tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Clock enable for the slow count rate |
| fast_tick | input | 1 | Clock enable for the fast count rate |
| addr | input | 8 | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| rdata | output | 32 | Registered read data |
| irq | output | 3 | Latched underflow interrupt, one per down-counter |

## Verification
The assertions take for granted that addresses are word aligned, that `wr_en` and `rd_en` are single-cycle pulses, and that the ticks are one-cycle strobes driven away from the clock edge. The stimulus keeps within this. It drives every input at the falling edge and only ever pulses each strobe for one cycle. It also programs each channel in the intended order: mode bits with enable clear, then the reload value, then enable. This matches the order the no-spurious-interrupt assumption relies on.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH        = 3;
  localparam int DATA_W        = 32;
  localparam int ADDR_W        = 8;
  localparam int FREE_W        = 40;
  localparam int HI_W          = FREE_W - DATA_W;
  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_PER_BIT  = 6;
  localparam int CTRL_FSEL_BIT = 3;
  localparam int FREE_EN_BIT   = 8;

  localparam logic [1:0] WORD_LOAD  = 2'd0;
  localparam logic [1:0] WORD_COUNT = 2'd1;
  localparam logic [1:0] WORD_CTRL  = 2'd2;
  localparam logic [1:0] WORD_CLEAR = 2'd3;

  localparam logic [ADDR_W-1:0] FREE_LO_ADDR = 8'h60;
  localparam logic [ADDR_W-1:0] FREE_HI_ADDR = 8'h64;

  typedef struct packed {
    logic en;
    logic per;
    logic fsel;
  } chan_ctrl_t;

  function automatic int chan_width(input int idx);
    return (idx == 2) ? 32 : 16;
  endfunction

  function automatic logic [ADDR_W-1:0] chan_base(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h20;
      default: return 8'h80;
    endcase
  endfunction
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_reload_chan.sv
module tmr_reload_chan
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic              ld_we,
  input  logic              ctrl_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] load_rd,
  output logic [DATA_W-1:0] count_rd,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic              irq
);
  localparam logic [W-1:0] ONE_W = W'(1);

  chan_ctrl_t ctrl_q, ctrl_d;
  logic [W-1:0] load_q, load_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         irq_q, irq_d;
  logic         tick_sel, step, under;

  always_comb begin
    tick_sel = ctrl_q.fsel ? fast_tick : slow_tick;
    step     = ctrl_q.en && tick_sel;
    under    = step && (cnt_q == '0) && !ld_we;

    load_d = ld_we ? wdata[W-1:0] : load_q;

    cnt_d = cnt_q;
    if (ld_we) begin
      cnt_d = wdata[W-1:0];
    end else if (step) begin
      if (cnt_q == '0) cnt_d = ctrl_q.per ? load_q : '1;
      else             cnt_d = cnt_q - ONE_W;
    end

    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.en   = wdata[CTRL_EN_BIT];
      ctrl_d.per  = wdata[CTRL_PER_BIT];
      ctrl_d.fsel = wdata[CTRL_FSEL_BIT];
    end

    irq_d = irq_q;
    if (under)       irq_d = 1'b1;
    else if (clr_we) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      cnt_q  <= cnt_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    load_rd                = '0;
    load_rd[W-1:0]         = load_q;
    count_rd               = '0;
    count_rd[W-1:0]        = cnt_q;
    ctrl_rd                = '0;
    ctrl_rd[CTRL_EN_BIT]   = ctrl_q.en;
    ctrl_rd[CTRL_PER_BIT]  = ctrl_q.per;
    ctrl_rd[CTRL_FSEL_BIT] = ctrl_q.fsel;
  end

  assign irq = irq_q;

  AST_RELOAD_ON_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
    (under && ctrl_q.per) |=> (cnt_q == $past(load_q))); // R5
  AST_WRAP_ON_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
    (under && !ctrl_q.per) |=> (&cnt_q)); // R6
  AST_IRQ_ON_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
    under |=> irq); // R7
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !under) |=> !irq); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !ld_we) |=> $stable(cnt_q)); // R3
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |=> (cnt_q == $past(wdata[W-1:0]))); // R4
endmodule

// File: rtl/tmr_free_ctr.sv
module tmr_free_ctr
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick,
  input  logic              en_we,
  input  logic              en_wdata,
  input  logic              lo_rd,
  output logic [DATA_W-1:0] lo_word,
  output logic [DATA_W-1:0] hi_word
);
  localparam logic [FREE_W-1:0] ONE_F = FREE_W'(1);

  logic              en_q, en_d;
  logic [FREE_W-1:0] cnt_q, cnt_d;
  logic [HI_W-1:0]   hold_q, hold_d;

  always_comb begin
    en_d   = en_we ? en_wdata : en_q;
    cnt_d  = (en_q && fast_tick) ? cnt_q + ONE_F : cnt_q;
    hold_d = lo_rd ? cnt_q[FREE_W-1:DATA_W] : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      en_q   <= en_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  always_comb begin
    lo_word              = cnt_q[DATA_W-1:0];
    hi_word              = '0;
    hi_word[HI_W-1:0]    = hold_q;
    hi_word[FREE_EN_BIT] = en_q;
  end

  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && fast_tick) |=> (cnt_q == $past(cnt_q) + ONE_F)); // R9
  AST_FREE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(cnt_q)); // R9
  AST_HI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> (hold_q == $past(cnt_q[FREE_W-1:DATA_W]))); // R10
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irq
);
  logic rst_sync_n;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [1:0]        word_idx;
  logic [NUM_CH-1:0] ch_sel;
  logic [DATA_W-1:0] ch_load  [NUM_CH];
  logic [DATA_W-1:0] ch_count [NUM_CH];
  logic [DATA_W-1:0] ch_ctrl  [NUM_CH];

  assign word_idx = addr[3:2];

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chan
    localparam logic [ADDR_W-1:0] BASE = chan_base(gi);
    assign ch_sel[gi] = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);

    tmr_reload_chan #(.W(chan_width(gi))) u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .slow_tick (slow_tick),
      .fast_tick (fast_tick),
      .ld_we     (wr_en && ch_sel[gi] && (word_idx == WORD_LOAD)),
      .ctrl_we   (wr_en && ch_sel[gi] && (word_idx == WORD_CTRL)),
      .clr_we    (wr_en && ch_sel[gi] && (word_idx == WORD_CLEAR)),
      .wdata     (wdata),
      .load_rd   (ch_load[gi]),
      .count_rd  (ch_count[gi]),
      .ctrl_rd   (ch_ctrl[gi]),
      .irq       (irq[gi])
    );
  end

  logic [DATA_W-1:0] free_lo, free_hi;

  tmr_free_ctr u_free (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fast_tick (fast_tick),
    .en_we     (wr_en && (addr == FREE_HI_ADDR)),
    .en_wdata  (wdata[FREE_EN_BIT]),
    .lo_rd     (rd_en && (addr == FREE_LO_ADDR)),
    .lo_word   (free_lo),
    .hi_word   (free_hi)
  );

  logic [DATA_W-1:0] rd_mux, rdata_q, rdata_d;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel[i]) begin
        case (word_idx)
          WORD_LOAD:  rd_mux = ch_load[i];
          WORD_COUNT: rd_mux = ch_count[i];
          WORD_CTRL:  rd_mux = ch_ctrl[i];
          default:    rd_mux = '0;
        endcase
      end
    end
    if (addr == FREE_LO_ADDR) rd_mux = free_lo;
    if (addr == FREE_HI_ADDR) rd_mux = free_hi;
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> $stable(rdata)); // R2
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(ch_sel)); // R2
endmodule

// File: tb/tb_tick_timer_bank.sv
module tb_tick_timer_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        fast_tick = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sbq[$];
  logic mon_fire = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer_bank dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .irq(irq)
  );

  always @(posedge clk) mon_fire <= rd_en;

  always @(negedge clk) begin
    if (mon_fire) begin
      if (sbq.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: read result with no expected item (rdata=%h)", rdata);
      end else begin
        sb_item_t it;
        it = sbq.pop_front();
        total++;
        if (rdata !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    sb_item_t it;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    input logic s = 1'b0, input logic f = 1'b0);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; slow_tick = s; fast_tick = f;
    @(negedge clk);
    wr_en = 1'b0; slow_tick = 1'b0; fast_tick = 1'b0;
  endtask

  task automatic ticks(input logic s, input logic f, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slow_tick = s; fast_tick = f;
      @(negedge clk);
      slow_tick = 1'b0; fast_tick = 1'b0;
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", {29'b0, irq}, 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);
    rd(8'h04, 32'h0, "R1 ch0 count");
    rd(8'h08, 32'h0, "R1 ch0 ctrl");
    rd(8'h80, 32'h0, "R1 ch2 load");
    rd(8'h60, 32'h0, "R1 free low");

    // R3 control bits, others read zero
    wr(8'h08, 32'hFFFF_FF77);
    rd(8'h08, 32'h0000_0040, "R3 ctrl masked");

    // R4 / R8 load copies into counter, upper bits dropped
    wr(8'h00, 32'h1234_0005);
    rd(8'h00, 32'h0000_0005, "R8 ch0 load masked");
    rd(8'h04, 32'h0000_0005, "R4 count copied");

    // R3 disabled channel holds
    ticks(1'b1, 1'b0, 3);
    rd(8'h04, 32'h0000_0005, "R3 disabled holds");

    // R11 slow-select channel ignores fast tick
    wr(8'h08, 32'h0000_00C0);
    ticks(1'b0, 1'b1, 4);
    rd(8'h04, 32'h0000_0005, "R11 fast ignored");

    // R5 N+1 tick period
    ticks(1'b1, 1'b0, 5);
    rd(8'h04, 32'h0000_0000, "R5 count reaches zero");
    chk("R7 no irq before underflow", {29'b0, irq}, 32'h0);
    ticks(1'b1, 1'b0, 1);
    chk("R7 irq on underflow", {29'b0, irq}, 32'h1);
    rd(8'h04, 32'h0000_0005, "R5 reload after underflow");

    // R7 clear of any value, and stays set until then
    ticks(1'b1, 1'b0, 2);
    chk("R7 irq sticky", {29'b0, irq}, 32'h1);
    wr(8'h0C, 32'h0000_DEAD);
    chk("R7 clear drops irq", {29'b0, irq}, 32'h0);
    rd(8'h0C, 32'h0, "R2 clear reads zero");
    ticks(1'b1, 1'b0, 3);
    rd(8'h04, 32'h0000_0000, "R5 count zero again");
    wr(8'h0C, 32'h1, 1'b1, 1'b0);
    chk("R7 underflow beats clear", {29'b0, irq}, 32'h1);
    rd(8'h04, 32'h0000_0005, "R5 reload on same-cycle clear");
    wr(8'h0C, 32'h0);
    chk("R7 cleared", {29'b0, irq}, 32'h0);

    // R4 load write wins over tick
    wr(8'h00, 32'h0000_0007, 1'b1, 1'b0);
    rd(8'h04, 32'h0000_0007, "R4 load beats tick");

    // R6 / R8 channel 1 non-periodic wraps on fast tick
    wr(8'h28, 32'h0000_0008);
    wr(8'h20, 32'h0000_0002);
    wr(8'h28, 32'h0000_0088);
    ticks(1'b0, 1'b1, 3);
    rd(8'h24, 32'h0000_FFFF, "R6 16-bit wrap");
    chk("R7 ch1 irq", {29'b0, irq}, 32'h2);
    rd(8'h04, 32'h0000_0007, "R11 ch0 untouched by fast");
    wr(8'h28, 32'h0);
    wr(8'h2C, 32'h0);

    // R8 channel 2 full width
    wr(8'h88, 32'h0000_0008);
    wr(8'h80, 32'h0000_0001);
    wr(8'h88, 32'h0000_0088);
    ticks(1'b0, 1'b1, 2);
    rd(8'h84, 32'hFFFF_FFFF, "R8 32-bit wrap");
    rd(8'h88, 32'h0000_0088, "R3 ch2 ctrl");
    chk("R7 ch2 irq", {29'b0, irq}, 32'h4);
    wr(8'h80, 32'hA5A5_5A5A);
    rd(8'h80, 32'hA5A5_5A5A, "R8 32-bit load");
    wr(8'h88, 32'h0);
    wr(8'h8C, 32'h0);
    chk("R7 all cleared", {29'b0, irq}, 32'h0);

    // R9 / R10 free-running counter
    rd(8'h64, 32'h0, "R10 high idle");
    wr(8'h64, 32'h0000_0100);
    ticks(1'b0, 1'b1, 5);
    rd(8'h60, 32'h0000_0005, "R9 free count");
    rd(8'h64, 32'h0000_0100, "R10 high snapshot and enable");
    chk("R9 no irq from free counter", {29'b0, irq}, 32'h0);
    wr(8'h64, 32'h0);
    ticks(1'b0, 1'b1, 3);
    rd(8'h60, 32'h0000_0005, "R9 stopped");
    rd(8'h64, 32'h0, "R10 enable clear");

    // R2 unmapped addresses
    rd(8'h10, 32'h0, "R2 unmapped 0x10");
    rd(8'h44, 32'h0, "R2 unmapped 0x44");

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: %0d reads never completed (expected 0)", sbq.size());
    end
    done = 1;
    summary();
  end
endmodule